// File: doc/BRIEF.md
# Chainable Interval Timer Channel

This block is one general-purpose timer channel: a 16-bit main counter extended by an 8-bit prescaler. It runs either once (one-shot) or continuously (periodic), counting down from an interval value or up from zero. A small write-only register port programs it: configuration, start/stop, interval, match values, prescale and a write-one-to-clear strobe. The live count and prescaler are visible on output ports.

Timers of this kind are chained. Each channel can emit a one-cycle trigger pulse at every time-out, and the next channel can be told to hold after being enabled until that pulse arrives. In periodic mode the channel can freeze its visible value at each time-out instead of showing the live count. Two sticky event flags drive a time-out interrupt and a match interrupt, each with its own gating bit.

Register addresses: 0 configuration, 1 control (bit 0 = enable/start), 2 interval, 3 match, 4 prescale, 5 prescale match, 6 clear (bit 0 = time-out flag, bit 1 = match flag). Configuration bits: [1:0] mode (0 idle, 1 one-shot, 2 periodic, 3 capture, treated as non-counting), [2] count up, [3] wait for chain trigger, [4] snapshot, [5] time-out interrupt disable (reset value 1), [6] match interrupt enable, [7] output trigger enable. All other configuration and value registers reset to 0.

Top module: `chain_timer`

## Requirements
- R1: After reset the channel is stopped, the value outputs read 0, and the interrupt and trigger outputs are low.
- R2: Counting down (configuration bit 2 = 0), a start loads the interval value, each step subtracts one, and the step after 0 reloads the interval and signals a time-out, giving a period of (interval+1) steps.
- R3: Counting up (configuration bit 2 = 1), a start clears the count to 0, each step adds one, and the step after reaching the interval returns to 0 and signals a time-out.
- R4: The main counter advances once every (prescale+1) clocks; a time-out needs both the main counter and the prescaler at their terminal values, so the period is (interval+1)*(prescale+1) clocks.
- R5: In one-shot mode (mode 1) the channel clears its own enable at the first time-out, holds its count at the terminal value and signals no further time-out.
- R6: With configuration bit 3 set, an enabled channel holds its count until a one-cycle pulse on trig_in, and counts from the clock after that pulse.
- R7: A time-out sets a sticky flag cleared by writing 1 to bit 0 of address 6; irq_timeout shows the flag only while configuration bit 5 is 0.
- R8: A match event occurs while counting when the count equals the match value and the prescaler equals the prescale match value; it sets a sticky flag (cleared by bit 1 of address 6) shown on irq_match only while configuration bit 6 is 1, and a new match value takes effect while running.
- R9: With configuration bit 7 set, trig_out is high for exactly the one clock after each time-out; with it clear, trig_out stays low.
- R10: In periodic mode with configuration bit 4 set, value_o and pre_value_o show the count and prescaler latched at the last time-out (0 after a start) instead of the live values.
- R11: Mode 0 and mode 3 do not count, even with enable set.
- R12: Writing 0 to bit 0 of address 1 stops the channel and holds its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| trig_in | input | 1 | Trigger pulse from the previous channel in the chain |
| irq_timeout | output | 1 | Gated time-out interrupt |
| irq_match | output | 1 | Gated match interrupt |
| trig_out | output | 1 | One-cycle trigger to the next channel |
| enabled | output | 1 | Current enable state |
| value_o | output | 16 | Live count, or snapshot in periodic snapshot mode |
| pre_value_o | output | 8 | Live prescaler, or its snapshot |

## Verification
The assertions watch, on every cycle, the relations between internal events and state: a time-out or match always raises its flag on the next clock, the time-out flag survives until a clear strobe, trig_out only follows a time-out, one-shot time-outs drop the enable, and the count never moves while the channel is disabled, waiting for a trigger or in a non-counting mode. Only the directed scenarios show the cycle-exact periods in both directions with and without prescaling, the effect of the gating bits on the interrupt pins, the frozen snapshot value, and the response to a match value rewritten mid-run.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        MODE_IDLE     = 2'd0,
        MODE_ONESHOT  = 2'd1,
        MODE_PERIODIC = 2'd2,
        MODE_CAPTURE  = 2'd3
    } mode_e;

    // Packed MSB-first so that bit 0 of the configuration word is mode[0].
    typedef struct packed {
        logic  trig_en;     // bit 7
        logic  match_ie;    // bit 6
        logic  to_irq_dis;  // bit 5
        logic  snap_en;     // bit 4
        logic  wait_trig;   // bit 3
        logic  count_up;    // bit 2
        mode_e mode;        // bits 1:0
    } cfg_t;

    localparam cfg_t CFG_RESET = '{
        trig_en:    1'b0,
        match_ie:   1'b0,
        to_irq_dis: 1'b1,
        snap_en:    1'b0,
        wait_trig:  1'b0,
        count_up:   1'b0,
        mode:       MODE_IDLE
    };

    localparam logic [ADDR_W-1:0] A_CFG    = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd1;
    localparam logic [ADDR_W-1:0] A_LOAD   = 3'd2;
    localparam logic [ADDR_W-1:0] A_MATCH  = 3'd3;
    localparam logic [ADDR_W-1:0] A_PRE    = 3'd4;
    localparam logic [ADDR_W-1:0] A_PMATCH = 3'd5;
    localparam logic [ADDR_W-1:0] A_CLEAR  = 3'd6;

endpackage

// File: rtl/ctmr_regs.sv
module ctmr_regs
    import ctmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              oneshot_done,
    output cfg_t              cfg,
    output logic              en,
    output logic [CNT_W-1:0]  load,
    output logic [CNT_W-1:0]  match,
    output logic [PRE_W-1:0]  pre_load,
    output logic [PRE_W-1:0]  pre_match,
    output logic              start,
    output logic              clr_to,
    output logic              clr_mt
);

    localparam int CFG_W = $bits(cfg_t);

    typedef struct packed {
        cfg_t             cfg;
        logic             en;
        logic [CNT_W-1:0] load;
        logic [CNT_W-1:0] match;
        logic [PRE_W-1:0] pre_load;
        logic [PRE_W-1:0] pre_match;
    } regs_s;

    regs_s regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        start  = 1'b0;
        clr_to = 1'b0;
        clr_mt = 1'b0;
        // Self-clear of the enable; a same-cycle software write wins below.
        if (oneshot_done) begin
            regs_d.en = 1'b0;
        end
        if (wr_en) begin
            case (wr_addr)
                A_CFG:    regs_d.cfg = cfg_t'(wr_data[CFG_W-1:0]);
                A_CTRL: begin
                    regs_d.en = wr_data[0];
                    start     = wr_data[0];
                end
                A_LOAD:   regs_d.load      = wr_data;
                A_MATCH:  regs_d.match     = wr_data;
                A_PRE:    regs_d.pre_load  = wr_data[PRE_W-1:0];
                A_PMATCH: regs_d.pre_match = wr_data[PRE_W-1:0];
                A_CLEAR: begin
                    clr_to = wr_data[0];
                    clr_mt = wr_data[1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.cfg       <= CFG_RESET;
            regs_q.en        <= 1'b0;
            regs_q.load      <= '0;
            regs_q.match     <= '0;
            regs_q.pre_load  <= '0;
            regs_q.pre_match <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign cfg       = regs_q.cfg;
    assign en        = regs_q.en;
    assign load      = regs_q.load;
    assign match     = regs_q.match;
    assign pre_load  = regs_q.pre_load;
    assign pre_match = regs_q.pre_match;

endmodule

// File: rtl/ctmr_core.sv
module ctmr_core
    import ctmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             en,
    input  mode_e            mode,
    input  logic             count_up,
    input  logic             wait_trig,
    input  logic [CNT_W-1:0] load,
    input  logic [CNT_W-1:0] match,
    input  logic [PRE_W-1:0] pre_load,
    input  logic [PRE_W-1:0] pre_match,
    input  logic             trig_in,
    output logic [CNT_W-1:0] cnt,
    output logic [PRE_W-1:0] pre,
    output logic             waiting,
    output logic             timeout_evt,
    output logic             match_evt
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [PRE_W-1:0] PRE_ONE = PRE_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [PRE_W-1:0] pre;
        logic             hold;
    } core_s;

    core_s core_d, core_q;

    logic             counting_mode;
    logic             run;
    logic             pre_term;
    logic             cnt_term;
    logic             tick;
    logic [CNT_W-1:0] cnt_init;
    logic [PRE_W-1:0] pre_init;

    always_comb begin
        counting_mode = (mode == MODE_ONESHOT) || (mode == MODE_PERIODIC);
        run           = en && !core_q.hold && counting_mode;
        // Up counting treats anything at or past the limit as terminal so a
        // limit lowered mid-run cannot cause a long wrap.
        pre_term      = count_up ? (core_q.pre >= pre_load) : (core_q.pre == '0);
        cnt_term      = count_up ? (core_q.cnt >= load)     : (core_q.cnt == '0);
        tick          = run && pre_term;
        timeout_evt   = tick && cnt_term;
        match_evt     = run && (core_q.cnt == match) && (core_q.pre == pre_match);
        cnt_init      = count_up ? '0 : load;
        pre_init      = count_up ? '0 : pre_load;

        core_d = core_q;
        if (start) begin
            core_d.cnt  = cnt_init;
            core_d.pre  = pre_init;
            core_d.hold = wait_trig;
        end else if (en && core_q.hold) begin
            if (trig_in) begin
                core_d.hold = 1'b0;
            end
        end else if (timeout_evt) begin
            // One-shot keeps the terminal count; periodic restarts.
            if (mode == MODE_PERIODIC) begin
                core_d.cnt = cnt_init;
                core_d.pre = pre_init;
            end
        end else if (tick) begin
            core_d.cnt = count_up ? core_q.cnt + CNT_ONE : core_q.cnt - CNT_ONE;
            core_d.pre = pre_init;
        end else if (run) begin
            core_d.pre = count_up ? core_q.pre + PRE_ONE : core_q.pre - PRE_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign cnt     = core_q.cnt;
    assign pre     = core_q.pre;
    assign waiting = en && core_q.hold;

endmodule

// File: rtl/ctmr_events.sv
module ctmr_events
    import ctmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  mode_e            mode,
    input  logic             snap_en,
    input  logic             trig_en,
    input  logic             timeout_evt,
    input  logic             match_evt,
    input  logic             clr_to,
    input  logic             clr_mt,
    input  logic [CNT_W-1:0] cnt,
    input  logic [PRE_W-1:0] pre,
    output logic             to_flag,
    output logic             mt_flag,
    output logic             trig_out,
    output logic [CNT_W-1:0] value_o,
    output logic [PRE_W-1:0] pre_value_o
);

    typedef struct packed {
        logic             to_flag;
        logic             mt_flag;
        logic             trig;
        logic [CNT_W-1:0] snap_cnt;
        logic [PRE_W-1:0] snap_pre;
    } evt_s;

    evt_s evt_d, evt_q;
    logic snap_active;

    always_comb begin
        snap_active   = snap_en && (mode == MODE_PERIODIC);
        evt_d         = evt_q;
        // New events win over a clear in the same cycle.
        evt_d.to_flag = (evt_q.to_flag && !clr_to) || timeout_evt;
        evt_d.mt_flag = (evt_q.mt_flag && !clr_mt) || match_evt;
        evt_d.trig    = timeout_evt && trig_en;
        if (start) begin
            evt_d.snap_cnt = '0;
            evt_d.snap_pre = '0;
        end else if (timeout_evt && snap_active) begin
            evt_d.snap_cnt = cnt;
            evt_d.snap_pre = pre;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= '0;
        end else begin
            evt_q <= evt_d;
        end
    end

    assign to_flag     = evt_q.to_flag;
    assign mt_flag     = evt_q.mt_flag;
    assign trig_out    = evt_q.trig;
    assign value_o     = snap_active ? evt_q.snap_cnt : cnt;
    assign pre_value_o = snap_active ? evt_q.snap_pre : pre;

endmodule

// File: rtl/chain_timer.sv
module chain_timer
    import ctmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              trig_in,
    output logic              irq_timeout,
    output logic              irq_match,
    output logic              trig_out,
    output logic              enabled,
    output logic [CNT_W-1:0]  value_o,
    output logic [PRE_W-1:0]  pre_value_o
);

    cfg_t             cfg;
    logic             en;
    logic [CNT_W-1:0] load;
    logic [CNT_W-1:0] match;
    logic [PRE_W-1:0] pre_load;
    logic [PRE_W-1:0] pre_match;
    logic             start;
    logic             clr_to;
    logic             clr_mt;
    logic [CNT_W-1:0] cnt;
    logic [PRE_W-1:0] pre;
    logic             waiting;
    logic             timeout_evt;
    logic             match_evt;
    logic             to_flag;
    logic             mt_flag;
    logic             oneshot_done;

    assign oneshot_done = timeout_evt && (cfg.mode == MODE_ONESHOT);

    ctmr_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .oneshot_done (oneshot_done),
        .cfg          (cfg),
        .en           (en),
        .load         (load),
        .match        (match),
        .pre_load     (pre_load),
        .pre_match    (pre_match),
        .start        (start),
        .clr_to       (clr_to),
        .clr_mt       (clr_mt)
    );

    ctmr_core #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .en          (en),
        .mode        (cfg.mode),
        .count_up    (cfg.count_up),
        .wait_trig   (cfg.wait_trig),
        .load        (load),
        .match       (match),
        .pre_load    (pre_load),
        .pre_match   (pre_match),
        .trig_in     (trig_in),
        .cnt         (cnt),
        .pre         (pre),
        .waiting     (waiting),
        .timeout_evt (timeout_evt),
        .match_evt   (match_evt)
    );

    ctmr_events #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_events (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .mode        (cfg.mode),
        .snap_en     (cfg.snap_en),
        .trig_en     (cfg.trig_en),
        .timeout_evt (timeout_evt),
        .match_evt   (match_evt),
        .clr_to      (clr_to),
        .clr_mt      (clr_mt),
        .cnt         (cnt),
        .pre         (pre),
        .to_flag     (to_flag),
        .mt_flag     (mt_flag),
        .trig_out    (trig_out),
        .value_o     (value_o),
        .pre_value_o (pre_value_o)
    );

    assign irq_timeout = to_flag && !cfg.to_irq_dis;
    assign irq_match   = mt_flag && cfg.match_ie;
    assign enabled     = en;

endmodule

// File: rtl/ctmr_checker.sv
module ctmr_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             enabled,
    input logic             waiting,
    input logic [1:0]       mode,
    input logic             timeout_evt,
    input logic             match_evt,
    input logic             to_flag,
    input logic             mt_flag,
    input logic             clr_to,
    input logic             trig_out,
    input logic [CNT_W-1:0] cnt
);

    a_r7_flag_on_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_evt |=> to_flag);

    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (to_flag && !clr_to) |=> to_flag);

    a_r8_flag_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |=> mt_flag);

    a_r9_trig_follows_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out |-> $past(timeout_evt));

    a_r5_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_evt && mode == 2'd1 && !start) |=> !enabled);

    a_r11_idle_mode_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'd0 || mode == 2'd3) && !start) |=> $stable(cnt));

    a_r12_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!enabled && !start) |=> $stable(cnt));

    a_r6_waiting_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && !start) |=> $stable(cnt));

endmodule

bind chain_timer ctmr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .enabled     (enabled),
    .waiting     (waiting),
    .mode        (cfg.mode),
    .timeout_evt (timeout_evt),
    .match_evt   (match_evt),
    .to_flag     (to_flag),
    .mt_flag     (mt_flag),
    .clr_to      (clr_to),
    .trig_out    (trig_out),
    .cnt         (cnt)
);

// File: tb/chain_timer_test.sv
module chain_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        trig_in = 1'b0;
    logic        irq_timeout, irq_match, trig_out, enabled;
    logic [15:0] value_o;
    logic [7:0]  pre_value_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    chain_timer uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .trig_in     (trig_in),
        .irq_timeout (irq_timeout),
        .irq_match   (irq_match),
        .trig_out    (trig_out),
        .enabled     (enabled),
        .value_o     (value_o),
        .pre_value_o (pre_value_o)
    );

    localparam logic [2:0] RA_CFG = 0, RA_CTRL = 1, RA_LOAD = 2, RA_MATCH = 3,
                           RA_PRE = 4, RA_PMATCH = 5, RA_CLEAR = 6;

    function automatic logic [15:0] cfgw(input int mode, input bit up, input bit wt,
                                         input bit snap, input bit dis,
                                         input bit mie, input bit ten);
        return {8'd0, ten, mie, dis, snap, wt, up, mode[1:0]};
    endfunction

    task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset;
        rst_n = 1'b0; wr_en = 1'b0; trig_in = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic setup(input int ld, input int ps, input int mt, input int pm,
                         input logic [15:0] cw);
        wr(RA_LOAD, 16'(ld));
        wr(RA_PRE, 16'(ps));
        wr(RA_MATCH, 16'(mt));
        wr(RA_PMATCH, 16'(pm));
        wr(RA_CFG, cw);
    endtask

    task automatic t_reset_state;
        do_reset();
        chk("R1 enabled", enabled, 0);
        chk("R1 value", value_o, 0);
        chk("R1 prescale value", pre_value_o, 0);
        chk("R1 irq_timeout", irq_timeout, 0);
        chk("R1 irq_match", irq_match, 0);
        chk("R1 trig_out", trig_out, 0);
    endtask

    task automatic t_down_count;
        do_reset();
        setup(5, 0, 100, 0, cfgw(2, 0, 0, 0, 0, 0, 0));
        wr(RA_CTRL, 1);
        chk("R2 start loads interval", value_o, 5);
        tick(3);
        chk("R2 counts down", value_o, 2);
        tick(2);
        chk("R2 reaches zero", value_o, 0);
        chk("R2 no early timeout", irq_timeout, 0);
        tick(1);
        chk("R2 reload after zero", value_o, 5);
        chk("R2 timeout at period", irq_timeout, 1);
    endtask

    task automatic t_up_count;
        do_reset();
        setup(4, 0, 100, 0, cfgw(2, 1, 0, 0, 0, 0, 0));
        wr(RA_CTRL, 1);
        chk("R3 starts at zero", value_o, 0);
        tick(4);
        chk("R3 reaches interval", value_o, 4);
        chk("R3 no early timeout", irq_timeout, 0);
        tick(1);
        chk("R3 wraps to zero", value_o, 0);
        chk("R3 timeout at wrap", irq_timeout, 1);
    endtask

    task automatic t_prescale;
        do_reset();
        setup(3, 2, 100, 0, cfgw(2, 0, 0, 0, 0, 0, 0));
        wr(RA_CTRL, 1);
        tick(2);
        chk("R4 count held by prescaler", value_o, 3);
        chk("R4 prescaler counts down", pre_value_o, 0);
        tick(1);
        chk("R4 step after prescale+1 clocks", value_o, 2);
        tick(8);
        chk("R4 no timeout before full period", irq_timeout, 0);
        tick(1);
        chk("R4 timeout after (L+1)(P+1)", irq_timeout, 1);
        chk("R4 reload after timeout", value_o, 3);
    endtask

    task automatic t_oneshot;
        do_reset();
        setup(3, 0, 100, 0, cfgw(1, 0, 0, 0, 0, 0, 0));
        wr(RA_CTRL, 1);
        tick(3);
        chk("R5 still enabled before timeout", enabled, 1);
        tick(1);
        chk("R5 enable self-cleared", enabled, 0);
        chk("R5 timeout raised", irq_timeout, 1);
        chk("R5 count held at terminal", value_o, 0);
        wr(RA_CLEAR, 1);
        tick(10);
        chk("R5 count still held", value_o, 0);
        chk("R5 no second timeout", irq_timeout, 0);
    endtask

    task automatic t_wait_trigger;
        do_reset();
        setup(4, 0, 100, 0, cfgw(2, 0, 1, 0, 0, 0, 0));
        wr(RA_CTRL, 1);
        tick(8);
        chk("R6 holds while waiting", value_o, 4);
        chk("R6 enabled while waiting", enabled, 1);
        trig_in = 1'b1;
        tick(1);
        trig_in = 1'b0;
        chk("R6 count at trigger edge", value_o, 4);
        tick(1);
        chk("R6 counts after trigger", value_o, 3);
    endtask

    task automatic t_timeout_irq;
        do_reset();
        setup(2, 0, 100, 0, cfgw(2, 0, 0, 0, 1, 0, 0));
        wr(RA_CTRL, 1);
        tick(3);
        chk("R7 irq gated by disable bit", irq_timeout, 0);
        wr(RA_CFG, cfgw(2, 0, 0, 0, 0, 0, 0));
        chk("R7 sticky flag visible once ungated", irq_timeout, 1);
        wr(RA_CLEAR, 1);
        chk("R7 write-one clears flag", irq_timeout, 0);
        tick(1);
        chk("R7 next timeout sets flag", irq_timeout, 1);
    endtask

    task automatic t_match;
        do_reset();
        setup(9, 0, 4, 0, cfgw(2, 0, 0, 0, 1, 1, 0));
        wr(RA_CTRL, 1);
        tick(5);
        chk("R8 no early match", irq_match, 0);
        tick(1);
        chk("R8 match flag at count==match", irq_match, 1);
        wr(RA_CLEAR, 2);
        chk("R8 match flag cleared", irq_match, 0);
        wr(RA_MATCH, 7);
        tick(4);
        chk("R8 new match not yet reached", irq_match, 0);
        tick(1);
        chk("R8 rewritten match takes effect", irq_match, 1);
        wr(RA_CFG, cfgw(2, 0, 0, 0, 1, 0, 0));
        chk("R8 irq gated by match enable", irq_match, 0);
        wr(RA_CFG, cfgw(2, 0, 0, 0, 1, 1, 0));
        chk("R8 flag sticky while gated", irq_match, 1);
    endtask

    task automatic t_trigger_out;
        int pulses;
        do_reset();
        setup(5, 0, 100, 0, cfgw(2, 0, 0, 0, 1, 0, 1));
        wr(RA_CTRL, 1);
        tick(5);
        chk("R9 no pulse before timeout", trig_out, 0);
        tick(1);
        chk("R9 pulse after timeout", trig_out, 1);
        tick(1);
        chk("R9 pulse lasts one cycle", trig_out, 0);
        tick(5);
        chk("R9 pulse each period", trig_out, 1);
        do_reset();
        setup(5, 0, 100, 0, cfgw(2, 0, 0, 0, 1, 0, 0));
        wr(RA_CTRL, 1);
        pulses = 0;
        for (int i = 0; i < 15; i++) begin
            tick(1);
            if (trig_out) pulses++;
        end
        chk("R9 no pulse with trigger disabled", pulses, 0);
    endtask

    task automatic t_snapshot;
        do_reset();
        setup(6, 1, 100, 0, cfgw(2, 1, 0, 1, 1, 0, 0));
        wr(RA_CTRL, 1);
        tick(13);
        chk("R10 snapshot zero after start", value_o, 0);
        tick(1);
        chk("R10 count latched at timeout", value_o, 6);
        chk("R10 prescaler latched at timeout", pre_value_o, 1);
        tick(6);
        chk("R10 snapshot frozen between timeouts", value_o, 6);
        wr(RA_CFG, cfgw(2, 1, 0, 0, 1, 0, 0));
        chk("R10 live value without snapshot", value_o, 3);
    endtask

    task automatic t_idle_modes;
        do_reset();
        setup(4, 0, 100, 0, cfgw(3, 0, 0, 0, 0, 0, 0));
        wr(RA_CTRL, 1);
        tick(8);
        chk("R11 capture mode does not count", value_o, 4);
        chk("R11 capture mode no timeout", irq_timeout, 0);
        do_reset();
        setup(4, 0, 100, 0, cfgw(0, 0, 0, 0, 0, 0, 0));
        wr(RA_CTRL, 1);
        tick(8);
        chk("R11 idle mode does not count", value_o, 4);
    endtask

    task automatic t_disable_hold;
        do_reset();
        setup(20, 0, 100, 0, cfgw(2, 0, 0, 0, 1, 0, 0));
        wr(RA_CTRL, 1);
        tick(5);
        chk("R12 running count", value_o, 15);
        wr(RA_CTRL, 0);
        chk("R12 last step at stop", value_o, 14);
        chk("R12 enable cleared", enabled, 0);
        tick(5);
        chk("R12 count held when stopped", value_o, 14);
    endtask

    initial begin
        tick(1);
        t_reset_state();
        t_down_count();
        t_up_count();
        t_prescale();
        t_oneshot();
        t_wait_trigger();
        t_timeout_irq();
        t_match();
        t_trigger_out();
        t_snapshot();
        t_idle_modes();
        t_disable_hold();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule